// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block holds a control bit and a flag bit for every device select code of a 6-bit code space (64 codes) and turns them into prioritised, vectored interrupts for a CPU. The CPU drives I/O operations at it (set or clear a device's control bit, set or clear its flag, test its flag for a conditional skip). Each device raises its flag with a one-cycle pulse when a transfer completes. A device whose control and flag bits are both set asks for service. The lowest code among the eligible devices wins. It is granted only on an instruction-boundary strobe while the interrupt system is switched on. The grant is reported as a one-cycle acknowledge carrying a vector equal to the device code.

A granted device stays in service for as long as its flag and control bits stay set. While it is in service it masks itself and every higher-numbered code, whose requests are held pending. Lower-numbered codes can still interrupt it, which gives nested service. When the CPU clears the in-service device's flag, the pending code with the highest priority becomes eligible on its own. Codes 0 through 3 are set aside for system functions. Their control and flag bits can be stored and tested, but they never request and never mask anyone.

Top module: `prio_vec_intc`

## Requirements
- R1: After a synchronous reset every control, flag and in-service bit is clear, and `irq`, `int_ack` and `skip` are 0.
- R2: Operation 3'b111 on the selected code sets its control bit when `io_sub`=0 and clears it when `io_sub`=1. No other input changes a control bit, and a device with its control bit clear never requests.
- R3: A one-cycle `dev_flag_set` pulse sets that device's flag. Operation 3'b001 sets the flag when `io_hc`=0 and clears it when `io_hc`=1. Any other operation with `io_hc`=1 clears the selected flag after the operation. A device pulse wins over a CPU clear in the same cycle.
- R4: Operation 3'b010 raises `skip` in the next cycle if the selected flag is clear. Operation 3'b011 raises it if the flag is set. The flag is sampled before any change made in the same cycle, and `skip` is 0 after every other cycle.
- R5: Only codes 4 and above with both control and flag set, and not already in service, can request. Codes 0 to 3 never request and never mask.
- R6: When `insn_boundary` and `int_enable` are both high and a request is eligible, the lowest eligible code is granted. In the next cycle `int_ack` is 1 for exactly one cycle and `int_vec` equals that code.
- R7: A device in service masks its own code and all higher codes, so it is not granted again and those requests wait. A lower code can still be granted.
- R8: Clearing the flag (or control bit) of an in-service device ends its service, and the lowest pending code then becomes eligible without any further action.
- R9: `irq` is 1 in the cycle after a cycle in which `int_enable` was high, a request was eligible and no grant was made.
- R10: With `int_enable` low no grant occurs and `irq` stays 0, while requests stay pending for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | An I/O operation is presented this cycle |
| io_op | input | 3 | Operation code |
| io_sel | input | 6 | Device select code of the operation |
| io_hc | input | 1 | Flag clear / flag set-clear select |
| io_sub | input | 1 | Control set (0) / clear (1) select for operation 3'b111 |
| dev_flag_set | input | 64 | Per-device flag-set pulses |
| int_enable | input | 1 | Interrupt system on |
| insn_boundary | input | 1 | Strobe marking an instruction boundary |
| irq | output | 1 | An eligible request is waiting |
| int_ack | output | 1 | One-cycle grant pulse |
| int_vec | output | 6 | Vector (device code) of the latest grant |
| skip | output | 1 | Result of the flag test of the previous cycle |

## Verification
On every cycle the assertions check a few things. A device pulse always leaves its flag set, and a control bit moves only on a control operation. A grant follows an enabled boundary strobe and never carries a code below 4. The chosen code is the lowest one asking for service. A skip always traces back to a flag test. Nested grants, masking of higher codes while a lower one is in service, and the release of a pending code once a flag is cleared all depend on the order of events. Only the bench's directed sequences and its model-compared random traffic can show those.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  localparam logic [2:0] OP_HALT     = 3'b000;
  localparam logic [2:0] OP_FLAG     = 3'b001;
  localparam logic [2:0] OP_SKIP_CLR = 3'b010;
  localparam logic [2:0] OP_SKIP_SET = 3'b011;
  localparam logic [2:0] OP_CTRL     = 3'b111;
endpackage

// File: rtl/pvi_slot.sv
module pvi_slot
  import pvi_pkg::*;
#(
  parameter bit CAN_REQ = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       io_hit,
  input  logic [2:0] io_op,
  input  logic       io_hc,
  input  logic       io_sub,
  input  logic       dev_set,
  input  logic       grant_me,
  output logic       flag_q,
  output logic       ctl_q,
  output logic       svc_q,
  output logic       blk
);
  logic flag_d, ctl_d, svc_d;

  always_comb begin
    flag_d = flag_q;
    if (io_hit) begin
      if (io_op == OP_FLAG) flag_d = ~io_hc;
      else if (io_hc)       flag_d = 1'b0;
    end
    if (dev_set) flag_d = 1'b1;
  end

  always_comb begin
    ctl_d = ctl_q;
    if (io_hit && io_op == OP_CTRL) ctl_d = ~io_sub;
  end

  assign svc_d = (svc_q | grant_me) & flag_d & ctl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ctl_q  <= 1'b0;
      svc_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ctl_q  <= ctl_d;
      svc_q  <= svc_d;
    end
  end

  assign blk = CAN_REQ & ctl_q & flag_q;

  // R3: a device pulse always leaves the flag set
  p_dev_set_flag_r3: assert property (@(posedge clk) disable iff (rst)
    dev_set |=> flag_q);

  // R2: control changes only through a control operation
  p_ctl_cpu_only_r2: assert property (@(posedge clk) disable iff (rst)
    !(io_hit && io_op == OP_CTRL) |=> $stable(ctl_q));
endmodule

// File: rtl/pvi_pick.sv
module pvi_pick #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvi_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int FIRST_REQ = 4,
  localparam int NUM_DEV  = 1 << CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               io_valid,
  input  logic [2:0]         io_op,
  input  logic [CODE_W-1:0]  io_sel,
  input  logic               io_hc,
  input  logic               io_sub,
  input  logic [NUM_DEV-1:0] dev_flag_set,
  input  logic               int_enable,
  input  logic               insn_boundary,
  output logic               irq,
  output logic               int_ack,
  output logic [CODE_W-1:0]  int_vec,
  output logic               skip
);
  logic [NUM_DEV-1:0] hit, gnt_me, flag_v, ctl_v, svc_v, blk_v;
  logic               found, eligible, grant;
  logic [CODE_W-1:0]  win_idx;
  logic [NUM_DEV-1:0] below_mask;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_slot
    assign hit[d]    = io_valid && (io_sel == CODE_W'(d));
    assign gnt_me[d] = grant && (win_idx == CODE_W'(d));
    pvi_slot #(.CAN_REQ(d >= FIRST_REQ)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .io_hit   (hit[d]),
      .io_op    (io_op),
      .io_hc    (io_hc),
      .io_sub   (io_sub),
      .dev_set  (dev_flag_set[d]),
      .grant_me (gnt_me[d]),
      .flag_q   (flag_v[d]),
      .ctl_q    (ctl_v[d]),
      .svc_q    (svc_v[d]),
      .blk      (blk_v[d])
    );
  end

  pvi_pick #(.N(NUM_DEV), .W(CODE_W)) u_pick (
    .req   (blk_v),
    .found (found),
    .idx   (win_idx)
  );

  assign eligible   = found && !svc_v[win_idx];
  assign grant      = eligible && int_enable && insn_boundary;
  assign below_mask = (NUM_DEV'(1) << win_idx) - NUM_DEV'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      int_ack <= 1'b0;
      int_vec <= '0;
      skip    <= 1'b0;
    end else begin
      irq     <= int_enable && eligible && !grant;
      int_ack <= grant;
      if (grant) int_vec <= win_idx;
      skip    <= io_valid &&
                 ((io_op == OP_SKIP_CLR && !flag_v[io_sel]) ||
                  (io_op == OP_SKIP_SET &&  flag_v[io_sel]));
    end
  end

  // R6: a grant follows an enabled boundary strobe
  p_ack_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    int_ack |-> $past(insn_boundary && int_enable));

  // R5: reserved codes are never vectored
  p_vec_not_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    int_ack |-> int_vec >= CODE_W'(FIRST_REQ));

  // R6: the selected code is the lowest one asking for service
  p_pick_lowest_r6: assert property (@(posedge clk) disable iff (rst)
    found |-> (blk_v[win_idx] && ((blk_v & below_mask) == '0)));

  // R4: a skip always traces back to a flag test
  p_skip_from_test_r4: assert property (@(posedge clk) disable iff (rst)
    skip |-> $past(io_valid && (io_op == OP_SKIP_CLR || io_op == OP_SKIP_SET)));

  // R9: a request output needs the interrupt system on
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(int_enable));
endmodule

// File: tb/tb_prio_vec_intc.sv
module tb_prio_vec_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_valid = 1'b0;
  logic [2:0]  io_op = 3'b000;
  logic [5:0]  io_sel = 6'd0;
  logic        io_hc = 1'b0;
  logic        io_sub = 1'b0;
  logic [63:0] dev_flag_set = '0;
  logic        int_enable = 1'b0;
  logic        insn_boundary = 1'b0;
  logic        irq, int_ack, skip;
  logic [5:0]  int_vec;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #4 clk = ~clk;

  prio_vec_intc dut (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_op(io_op), .io_sel(io_sel),
    .io_hc(io_hc), .io_sub(io_sub), .dev_flag_set(dev_flag_set),
    .int_enable(int_enable), .insn_boundary(insn_boundary),
    .irq(irq), .int_ack(int_ack), .int_vec(int_vec), .skip(skip)
  );

  // behavioural reference
  bit m_ctl[64], m_flg[64], m_ins[64];
  bit exp_irq, exp_ack, exp_skip;
  int exp_vec;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      foreach (m_ctl[i]) begin m_ctl[i] = 0; m_flg[i] = 0; m_ins[i] = 0; end
      exp_irq = 0; exp_ack = 0; exp_skip = 0;
    end else begin
      int w;
      bit have, elig, gr;
      have = 0; w = 0;
      for (int d = 4; d < 64; d++)
        if (!have && m_ctl[d] && m_flg[d]) begin have = 1; w = d; end
      elig = have && !m_ins[w];
      gr = elig && int_enable && insn_boundary;
      exp_ack = gr;
      if (gr) begin exp_vec = w; m_ins[w] = 1; end
      exp_irq = int_enable && elig && !gr;
      exp_skip = io_valid && ((io_op == 3'b010 && !m_flg[io_sel]) ||
                              (io_op == 3'b011 &&  m_flg[io_sel]));
      if (io_valid) begin
        if (io_op == 3'b001) m_flg[io_sel] = !io_hc;
        else if (io_hc) m_flg[io_sel] = 0;
        if (io_op == 3'b111) m_ctl[io_sel] = !io_sub;
      end
      for (int d = 0; d < 64; d++) if (dev_flag_set[d]) m_flg[d] = 1;
      for (int d = 0; d < 64; d++) if (!m_flg[d] || !m_ctl[d]) m_ins[d] = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(irq == exp_irq, "R9 irq vs model", irq, exp_irq);
      chk(int_ack == exp_ack, "R6 int_ack vs model", int_ack, exp_ack);
      chk(skip == exp_skip, "R4 skip vs model", skip, exp_skip);
      if (exp_ack) chk(int_vec == exp_vec, "R6 int_vec vs model", int_vec, exp_vec);
    end
  end

  task automatic do_io(input logic [2:0] op, input int sel, input bit hc, input bit sub);
    io_valid = 1; io_op = op; io_sel = sel[5:0]; io_hc = hc; io_sub = sub;
    @(negedge clk);
    io_valid = 0; io_hc = 0; io_sub = 0;
  endtask

  task automatic pulse(input int d);
    dev_flag_set[d] = 1'b1;
    @(negedge clk);
    dev_flag_set = '0;
  endtask

  task automatic bnd();
    insn_boundary = 1;
    @(negedge clk);
    insn_boundary = 0;
  endtask

  task automatic expect_ack(input int v, input string tag);
    bnd();
    chk(int_ack == 1'b1, tag, int_ack, 1);
    chk(int_vec == v[5:0], tag, int_vec, v);
  endtask

  task automatic expect_no_ack(input string tag);
    bnd();
    chk(int_ack == 1'b0, tag, int_ack, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int cand[8];
    cand = '{2, 4, 5, 7, 9, 12, 33, 63};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(irq == 0 && int_ack == 0 && skip == 0, "R1 outputs after reset", {irq, int_ack, skip}, 0);
    do_io(3'b010, 10, 0, 0);
    chk(skip == 1, "R1 flag clear after reset (R4 skip-if-clear)", skip, 1);
    do_io(3'b011, 10, 0, 0);
    chk(skip == 0, "R4 skip-if-set on clear flag", skip, 0);
    // R3 flag handling
    do_io(3'b001, 10, 0, 0);
    do_io(3'b011, 10, 0, 0);
    chk(skip == 1, "R3 set flag by operation", skip, 1);
    do_io(3'b001, 10, 1, 0);
    do_io(3'b011, 10, 0, 0);
    chk(skip == 0, "R3 clear flag by operation", skip, 0);
    pulse(10);
    do_io(3'b011, 10, 0, 0);
    chk(skip == 1, "R3 device pulse sets flag", skip, 1);
    do_io(3'b011, 10, 1, 0);
    chk(skip == 1, "R4 test samples flag before clear", skip, 1);
    do_io(3'b011, 10, 0, 0);
    chk(skip == 0, "R3 hc clears after test", skip, 0);
    dev_flag_set[10] = 1'b1;
    do_io(3'b001, 10, 1, 0);
    dev_flag_set = '0;
    do_io(3'b011, 10, 0, 0);
    chk(skip == 1, "R3 device pulse wins over clear", skip, 1);
    // R2 control needed
    int_enable = 1;
    expect_no_ack("R2 no grant without control");
    chk(irq == 0, "R9 irq low without control", irq, 0);
    do_io(3'b111, 10, 0, 0);
    @(negedge clk);
    chk(irq == 1, "R9 irq after control set", irq, 1);
    expect_ack(10, "R6 grant code 10");
    @(negedge clk);
    chk(irq == 0, "R7 in-service code does not re-request", irq, 0);
    expect_no_ack("R7 no second grant of in-service code");
    // R7 nesting
    do_io(3'b111, 20, 0, 0);
    pulse(20);
    expect_no_ack("R7 higher code masked");
    do_io(3'b111, 6, 0, 0);
    pulse(6);
    expect_ack(6, "R7 lower code interrupts");
    // R8 release
    do_io(3'b001, 6, 1, 0);
    expect_no_ack("R8 code 10 still masks 20");
    do_io(3'b001, 10, 1, 0);
    expect_ack(20, "R8 pending code released");
    do_io(3'b001, 20, 1, 0);
    // R5 reserved codes
    do_io(3'b111, 2, 0, 0);
    do_io(3'b001, 2, 0, 0);
    expect_no_ack("R5 code 2 never requests");
    chk(irq == 0, "R5 irq low for code 2", irq, 0);
    do_io(3'b111, 4, 0, 0);
    pulse(4);
    expect_ack(4, "R5 code 4 requests");
    do_io(3'b001, 4, 1, 0);
    // R10 and lowest wins
    int_enable = 0;
    foreach (cand[k]) if (cand[k] == 9 || cand[k] == 33) begin
      do_io(3'b111, cand[k], 0, 0);
      pulse(cand[k]);
    end
    do_io(3'b111, 40, 0, 0);
    pulse(40);
    expect_no_ack("R10 no grant while disabled");
    @(negedge clk);
    chk(irq == 0, "R10 irq low while disabled", irq, 0);
    int_enable = 1;
    expect_ack(9, "R6 lowest of 9/33/40 wins");
    do_io(3'b001, 9, 1, 0);
    expect_ack(33, "R8 next pending 33");
    do_io(3'b001, 33, 1, 0);
    expect_ack(40, "R8 next pending 40");
    do_io(3'b111, 40, 1, 0);
    do_io(3'b011, 40, 0, 0);
    chk(skip == 0, "R3 hc on control op clears flag", skip, 0);
    expect_no_ack("R8 service ended, nothing pending");
    // R2 clear control
    do_io(3'b111, 50, 0, 0);
    pulse(50);
    do_io(3'b111, 50, 0, 1);
    expect_no_ack("R2 cleared control stops request");
    @(negedge clk);
    chk(irq == 0, "R2 irq low after control clear", irq, 0);
    // random traffic compared with the model
    for (int c = 0; c < 4000; c++) begin
      io_valid = ($urandom % 3) == 0;
      io_op = 3'($urandom % 8);
      io_sel = 6'(cand[$urandom % 8]);
      io_hc = ($urandom % 4) == 0;
      io_sub = ($urandom % 3) == 0;
      dev_flag_set = '0;
      if (($urandom % 4) == 0) dev_flag_set[cand[$urandom % 8]] = 1'b1;
      insn_boundary = ($urandom % 3) == 0;
      int_enable = ($urandom % 12) != 0;
      @(negedge clk);
    end
    io_valid = 0; dev_flag_set = '0; insn_boundary = 0;
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule